// File: doc/BRIEF.md
# Pipelined Memory Target with Wait States and Error Response

This block is a word-organised memory that sits as a target on a single-clock, two-phase pipelined system bus. An address phase (address, transfer kind, direction and access size) is taken on a rising edge only when the shared bus ready is high and the target is selected with an active transfer kind. The data phase starts on that same edge and lasts until the first later edge at which the target's ready output is high. The number of wait states for each access is read from a configuration input when the address phase is taken.

Reads return the addressed word in the cycle where ready goes high. Writes merge the selected byte lanes into memory on the completing edge. Addresses inside a range set by parameters are rejected. The block first spends any wait states it was given. It then drives the two-cycle error response and leaves memory untouched. Because the shared ready stays low during wait states and during the first error cycle, the next address phase that the initiator is presenting stays pending. It is taken on the edge that completes the current data phase.

Top module: `pbus_mem_target`

## Requirements
- R1: After a synchronous reset, ready output is 1 and response is OKAY (0).
- R2: An active address phase presented while the ready input is 0 is not taken. Ready output stays 1 and memory is not changed.
- R3: With a wait count of 0, a read completes in the cycle after the address phase is taken. In that cycle ready output is 1 and read data holds the stored word at word index (addr / 4) mod DEPTH.
- R4: With a wait count of N, ready output is 0 for exactly N cycles after the address phase is taken and 1 in the cycle after those.
- R5: A write commits on its completing edge. Size codes are 0 for a byte, 1 for a halfword and 2 for a word. The size and addr[1:0] select the byte lanes, and other lanes keep their old value.
- R6: For an address in [ERR_LO, ERR_HI], after the N wait cycles the response is ERROR (1) with ready 0 for one cycle. It is then ERROR with ready 1 for one cycle.
- R7: A write that ends with an ERROR response leaves memory unchanged.
- R8: Transfer kinds IDLE (0) and BUSY (1), or a deselected address phase, start no data phase. Ready stays 1, the response stays OKAY and memory is not changed.
- R9: The response is OKAY during wait cycles and on every non-error completion.
- R10: An address phase presented during a waited data phase is held off and taken on the completing edge. A read of a just-written word sees the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge only |
| rst | input | 1 | Synchronous active-high reset |
| sel_i | input | 1 | Target selected for this address phase |
| addr_i | input | AW | Byte address |
| trans_i | input | 2 | Transfer kind: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| write_i | input | 1 | 1 for write, 0 for read |
| size_i | input | 3 | Access size code |
| wdata_i | input | 32 | Write data, valid in the data phase |
| ready_i | input | 1 | Shared bus ready; address phase taken only when high |
| wait_cfg_i | input | WW | Wait states inserted for the next taken access |
| rdata_o | output | 32 | Read data |
| ready_o | output | 1 | Target ready; high ends the data phase |
| resp_o | output | 1 | Response: 0 OKAY, 1 ERROR |

## Verification
The bench sweeps every size and lane offset under wait counts of 0 to 3. A target that miscounts waits would raise ready one cycle early or late. A target with wrong lane logic would corrupt neighbouring bytes on readback. Errored writes are run with and without waits, then read back through an aliased legal address. A target that wrote before deciding the error, or gave a one-cycle error, would show this in the data or in the ready and response pair. Stimulus with ready held low, with idle or busy kinds, and with a deselected target checks that nothing is taken. A back-to-back write followed by a read of the same word catches a target that takes the pending address phase early or reads stale data.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic [1:0] {
        TR_IDLE   = 2'd0,
        TR_BUSY   = 2'd1,
        TR_NONSEQ = 2'd2,
        TR_SEQ    = 2'd3
    } trans_e;

    typedef enum logic {
        RSP_OKAY  = 1'b0,
        RSP_ERROR = 1'b1
    } resp_e;

    typedef struct packed {
        logic [31:0] addr;
        logic        write;
        logic [2:0]  size;
        logic        err;
    } aphase_t;

    function automatic logic kind_active(input logic [1:0] tr);
        return tr == TR_NONSEQ || tr == TR_SEQ;
    endfunction

    function automatic logic [3:0] lane_mask(input logic [2:0] sz, input logic [1:0] off);
        logic [3:0] m;
        case (sz)
            3'd0:    m = 4'b0001 << off;
            3'd1:    m = off[1] ? 4'b1100 : 4'b0011;
            default: m = 4'b1111;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pbus_aphase.sv
module pbus_aphase
    import pbus_pkg::*;
#(
    parameter int AW     = 12,
    parameter int ERR_LO = 'h300,
    parameter int ERR_HI = 'h3FF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    trans_i,
    input  logic          write_i,
    input  logic [2:0]    size_i,
    input  logic          ready_i,
    output logic          take_o,
    output aphase_t       ap_o
);
    logic hit;

    assign take_o = ready_i && sel_i && kind_active(trans_i);
    assign hit    = (32'(addr_i) >= 32'(ERR_LO)) && (32'(addr_i) <= 32'(ERR_HI));

    always_ff @(posedge clk) begin
        if (rst) begin
            ap_o <= '0;
        end else if (take_o) begin
            ap_o.addr  <= 32'(addr_i);
            ap_o.write <= write_i;
            ap_o.size  <= size_i;
            ap_o.err   <= hit;
        end
    end

    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> $stable(ap_o));

endmodule

// File: rtl/pbus_dphase_ctl.sv
module pbus_dphase_ctl
    import pbus_pkg::*;
#(
    parameter int WW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          take_i,
    input  logic [WW-1:0] waits_i,
    input  logic          err_i,
    output logic          ready_o,
    output resp_e         resp_o,
    output logic          done_o
);
    logic          act;
    logic [WW-1:0] cnt;
    logic          err2;

    assign ready_o = !act || (cnt == '0 && (!err_i || err2));
    assign resp_o  = (act && err_i && cnt == '0) ? RSP_ERROR : RSP_OKAY;
    assign done_o  = act && ready_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            act  <= 1'b0;
            cnt  <= '0;
            err2 <= 1'b0;
        end else if (take_i) begin
            act  <= 1'b1;
            cnt  <= waits_i;
            err2 <= 1'b0;
        end else if (done_o) begin
            act  <= 1'b0;
        end else if (act) begin
            if (cnt != '0)
                cnt <= cnt - 1'b1;
            else if (err_i)
                err2 <= 1'b1;
        end
    end

    assert_err_second_R6: assert property (@(posedge clk) disable iff (rst)
        (resp_o == RSP_ERROR && !ready_o) |=> (resp_o == RSP_ERROR && ready_o));

    assert_err_first_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(resp_o == RSP_ERROR) |-> !ready_o);

    assert_wait_okay_R9: assert property (@(posedge clk) disable iff (rst)
        (!ready_o && !$past(!ready_o)) |-> resp_o == RSP_OKAY || err_i);

endmodule

// File: rtl/pbus_word_store.sv
module pbus_word_store #(
    parameter int DEPTH = 64,
    localparam int IW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [3:0]    be_i,
    input  logic [IW-1:0] idx_i,
    input  logic [31:0]   wdata_i,
    output logic [31:0]   rdata_o
);
    for (genvar b = 0; b < 4; b++) begin : g_lane
        logic [7:0] lane_q [DEPTH];

        always_ff @(posedge clk) begin
            if (we_i && be_i[b])
                lane_q[idx_i] <= wdata_i[8*b +: 8];
        end

        assign rdata_o[8*b +: 8] = lane_q[idx_i];
    end
endmodule

// File: rtl/pbus_mem_target.sv
module pbus_mem_target
    import pbus_pkg::*;
#(
    parameter int AW     = 12,
    parameter int DEPTH  = 64,
    parameter int WW     = 4,
    parameter int ERR_LO = 'h300,
    parameter int ERR_HI = 'h3FF
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sel_i,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    trans_i,
    input  logic          write_i,
    input  logic [2:0]    size_i,
    input  logic [31:0]   wdata_i,
    input  logic          ready_i,
    input  logic [WW-1:0] wait_cfg_i,
    output logic [31:0]   rdata_o,
    output logic          ready_o,
    output logic          resp_o
);
    localparam int IW = $clog2(DEPTH);

    logic    take;
    aphase_t ap;
    resp_e   rsp;
    logic    done;
    logic    we;

    pbus_aphase #(.AW(AW), .ERR_LO(ERR_LO), .ERR_HI(ERR_HI)) u_ap (
        .clk(clk), .rst(rst), .sel_i(sel_i), .addr_i(addr_i),
        .trans_i(trans_i), .write_i(write_i), .size_i(size_i),
        .ready_i(ready_i), .take_o(take), .ap_o(ap)
    );

    pbus_dphase_ctl #(.WW(WW)) u_ctl (
        .clk(clk), .rst(rst), .take_i(take), .waits_i(wait_cfg_i),
        .err_i(ap.err), .ready_o(ready_o), .resp_o(rsp), .done_o(done)
    );

    assign we     = done && ap.write && !ap.err;
    assign resp_o = rsp;

    pbus_word_store #(.DEPTH(DEPTH)) u_mem (
        .clk(clk), .we_i(we), .be_i(lane_mask(ap.size, ap.addr[1:0])),
        .idx_i(ap.addr[IW+1:2]), .wdata_i(wdata_i), .rdata_o(rdata_o)
    );

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (ready_o && !resp_o));

    assert_no_err_write_R7: assert property (@(posedge clk) disable iff (rst)
        we |-> !resp_o);

endmodule

// File: tb/pbus_mem_target_tb_top.sv
module pbus_mem_target_tb_top;
    localparam int DEPTH = 64;

    logic        clk = 0;
    logic        rst = 1;
    logic        sel = 0;
    logic [11:0] addr = 0;
    logic [1:0]  trans = 0;
    logic        write = 0;
    logic [2:0]  size = 0;
    logic [31:0] wdata = 0;
    logic [3:0]  wcfg = 0;
    logic        force_nr = 0;
    logic        rdy_in;
    logic [31:0] rdata;
    logic        ready;
    logic        resp;

    int total = 0;
    int bad = 0;
    logic [31:0] model [DEPTH];

    always #2 clk = ~clk;
    assign rdy_in = force_nr ? 1'b0 : ready;

    pbus_mem_target dut_i (
        .clk(clk), .rst(rst), .sel_i(sel), .addr_i(addr), .trans_i(trans),
        .write_i(write), .size_i(size), .wdata_i(wdata), .ready_i(rdy_in),
        .wait_cfg_i(wcfg), .rdata_o(rdata), .ready_o(ready), .resp_o(resp)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d);
        int nb = 1 << sz;
        int base = (sz == 0) ? a % 4 : (sz == 1) ? (a % 4) / 2 * 2 : 0;
        int ix = (a / 4) % DEPTH;
        for (int b = 0; b < 4; b++)
            if (b >= base && b < base + nb)
                model[ix][8*b +: 8] = d[8*b +: 8];
    endtask

    // called just after a rising edge; returns just after the completing edge
    task automatic xfer(input logic w, input logic [11:0] a, input logic [2:0] sz,
                        input logic [31:0] d, input int nw, input bit experr, input string req);
        sel = 1; trans = 2; write = w; addr = a; size = sz; wcfg = 4'(nw);
        @(posedge clk); #1;
        sel = 0; trans = 0; wdata = d;
        for (int i = 0; i < nw; i++) begin
            @(negedge clk);
            chk({req, " R4 wait ready"}, 32'(ready), 0);
            chk({req, " R9 wait resp"}, 32'(resp), 0);
            @(posedge clk); #1;
        end
        if (experr) begin
            @(negedge clk);
            chk({req, " R6 err1"}, {30'd0, ready, resp}, 32'b01);
            @(posedge clk); #1;
            @(negedge clk);
            chk({req, " R6 err2"}, {30'd0, ready, resp}, 32'b11);
        end else begin
            @(negedge clk);
            chk({req, " R4 done ready R9 resp"}, {30'd0, ready, resp}, 32'b10);
            if (!w) chk({req, " R3 rdata"}, rdata, model[(a / 4) % DEPTH]);
            if (w) model_write(a, sz, d);
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) model[i] = 'x;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 reset ready/resp", {30'd0, ready, resp}, 32'b10);
        @(posedge clk); #1;

        // initialise all words with full-word writes
        for (int i = 0; i < DEPTH; i++)
            xfer(1, 12'(i * 4), 2, 32'hA5000000 + 32'(i * 32'h01010101), 0, 0, "R5 init");

        // sweep waits x sizes x offsets with readback
        for (int nw = 0; nw < 4; nw++) begin
            for (int sz = 0; sz < 3; sz++) begin
                for (int off = 0; off < 4; off++) begin
                    if ((sz == 1 && off % 2 != 0) || (sz == 2 && off != 0)) continue;
                    begin
                        logic [11:0] a = 12'(32 + nw * 12 + sz * 4) * 4 + 12'(off);
                        xfer(1, a, 3'(sz), $urandom, nw, 0, "R5 write");
                        xfer(0, a, 3'(sz), 0, nw, 0, "R3 R5 readback");
                    end
                end
            end
        end

        // error range: writes rejected, memory unchanged via alias
        xfer(1, 12'h010, 2, 32'h11223344, 0, 0, "R5 pre");
        xfer(1, 12'h310, 2, 32'hDEADBEEF, 0, 1, "R6 R7 err w0");
        xfer(1, 12'h311, 0, 32'hCAFEF00D, 2, 1, "R6 R7 err w2");
        xfer(0, 12'h3FC, 2, 0, 1, 1, "R6 err read");
        xfer(0, 12'h010, 2, 0, 0, 0, "R7 alias readback");

        // ready input low: address phase not taken
        force_nr = 1; sel = 1; trans = 2; write = 1; addr = 12'h014; size = 2; wcfg = 3;
        @(posedge clk); #1;
        force_nr = 0; sel = 0; trans = 0; wdata = 32'h99999999;
        @(negedge clk);
        chk("R2 ready stays", 32'(ready), 1);
        @(posedge clk); #1;
        xfer(0, 12'h014, 2, 0, 0, 0, "R2 readback");

        // idle, busy, deselected
        for (int k = 0; k < 3; k++) begin
            sel = (k != 2); trans = (k == 2) ? 2'd2 : 2'(k); write = 1;
            addr = 12'h018; size = 2; wcfg = 2;
            @(posedge clk); #1;
            sel = 0; trans = 0; wdata = 32'h77777777;
            @(negedge clk);
            chk("R8 no data phase", {30'd0, ready, resp}, 32'b10);
            @(posedge clk); #1;
        end
        xfer(0, 12'h018, 2, 0, 0, 0, "R8 readback");

        // pipelined: write then read same word, read phase pending during waits
        sel = 1; trans = 2; write = 1; addr = 12'h020; size = 2; wcfg = 2;
        @(posedge clk); #1;
        write = 0; trans = 3; wdata = 32'h0BADCAFE;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10 held wait", 32'(ready), 0);
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk("R10 write done", {30'd0, ready, resp}, 32'b10);
        @(posedge clk); #1;
        sel = 0; trans = 0;
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            chk("R10 read wait", 32'(ready), 0);
            @(posedge clk); #1;
        end
        @(negedge clk);
        chk("R10 read ready", 32'(ready), 1);
        chk("R10 read data", rdata, 32'h0BADCAFE);
        @(posedge clk); #1;

        // synchronous reset mid-stream
        sel = 1; trans = 2; write = 0; addr = 12'h000; wcfg = 3;
        @(posedge clk); #1;
        sel = 0; trans = 0; rst = 1;
        @(posedge clk); #1;
        rst = 0;
        @(negedge clk);
        chk("R1 reset aborts", {30'd0, ready, resp}, 32'b10);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule